// File: doc/BRIEF.md
# Synthesizer Control Register Receiver

This block is a write-only serial-bus target that holds the setting of a frequency synthesizer. It samples the two bus lines with the system clock and finds START and STOP conditions from them. It checks the address byte and acknowledges every byte it takes. The settings are a 12-bit divider word, a 3-bit test code and one output-port control bit.

After the address, each data byte selects its own destination with its top bit. The divider word is built from fields that are split across the two register groups. Its two lowest bits are hardwired. Either group can therefore be rewritten on its own, and the two bytes may arrive in any order within one transfer.

A valid flag reports that both groups have been loaded at least once since reset. The system clock must run at least 8 times faster than the bus clock. The block only pulls the data line low. The pad and the pull-up that make the open-drain line are outside it.

Top module: `synth_ctl_rx`

## Requirements
- R1: An address byte of 0xC8 (7-bit address 0x64, write) is acknowledged. Any other address byte, including 0xC9, is not acknowledged, and every later byte of that transfer is neither acknowledged nor stored.
- R2: A data byte whose bit 7 is 0 loads its bits 6..0 into divider bits div_o[11:5].
- R3: A data byte whose bit 7 is 1 loads the test code, the port bit and the low divider bits: bit 6 to test_o[0], bit 5 to test_o[1], bit 4 to test_o[2], bit 3 to port_o, and bits 2..0 to div_o[4:2].
- R4: div_o[1:0] is always 2'b01. After reset, div_o is 12'h001, and test_o and port_o are 0.
- R5: valid_o is 0 after reset and stays 0 until at least one byte of each group has been stored. It then stays 1 until the next reset.
- R6: A stored byte changes only its own group. The fields of the other group keep their values.
- R7: sda_oe_o is 1 throughout the ninth bus clock of every accepted byte and is 0 otherwise. It changes only while scl_i is low.
- R8: A STOP or a repeated START in the middle of a byte discards the partial byte, and no register changes. After a repeated START the next byte is treated as an address.
- R9: A transfer may carry one data byte or several data bytes, in any group order. Each data byte is acknowledged and stored in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| div_o | output | 12 | Divider word N |
| test_o | output | 3 | Test code {T2,T1,T0} |
| port_o | output | 1 | Output-port control bit |
| valid_o | output | 1 | Both register groups loaded since reset |

## Verification
Two things can happen in the same transfer window: the receiver may be partway through shifting a byte when a START or STOP condition arrives. The bench provokes this by breaking off a data byte after a few bits with a repeated START, and in a separate case with a STOP. It then starts a correct transfer. The bench judges the result by two things: the outputs are unchanged after the broken byte, and the next address is acknowledged and its data byte lands in the right group. A second coincidence happens when one stored byte both updates its group and completes the valid condition. The bench checks this by sending a group-2 byte alone first and watching valid_o rise only when group 1 follows.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_DATA,
    ST_ACK_DATA,
    ST_SKIP
  } rx_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges while the clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/byte_rx_engine.sv
module byte_rx_engine
  import synth_ctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_BYTE = 8'hC8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              ack_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ack_o   <= 1'b0;
      wr_o    <= 1'b0;
    end else begin
      wr_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        ack_o   <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        ack_o   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && cnt_q != FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              if (state_q == ST_ADDR) begin
                if (sh_q == ADDR_BYTE) begin
                  ack_o   <= 1'b1;
                  state_q <= ST_ACK_ADDR;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else begin
                ack_o   <= 1'b1;
                wr_o    <= 1'b1;
                state_q <= ST_ACK_DATA;
              end
            end
          end
          ST_ACK_ADDR, ST_ACK_DATA: begin
            if (scl_fall_i) begin
              ack_o   <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end

  assign byte_o = sh_q;
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_ctl_pkg::*;
#(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned TEST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [TEST_W-1:0] test_o,
  output logic              port_o,
  output logic              valid_o
);
  localparam int unsigned HI_W = BYTE_W - 1;
  localparam int unsigned LO_W = DIV_W - HI_W - 2;

  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_q;
  logic [TEST_W-1:0] test_q;
  logic              port_q, got_hi_q, got_lo_q;
  logic [TEST_W-1:0] test_d;

  // byte bit 6 is the test LSB: reverse the field
  for (genvar i = 0; i < TEST_W; i++) begin : g_test
    assign test_d[i] = byte_i[BYTE_W-2-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hi_q     <= '0;
      lo_q     <= '0;
      test_q   <= '0;
      port_q   <= 1'b0;
      got_hi_q <= 1'b0;
      got_lo_q <= 1'b0;
    end else if (wr_i) begin
      if (!byte_i[BYTE_W-1]) begin
        hi_q     <= byte_i[HI_W-1:0];
        got_hi_q <= 1'b1;
      end else begin
        lo_q     <= byte_i[LO_W-1:0];
        port_q   <= byte_i[LO_W];
        test_q   <= test_d;
        got_lo_q <= 1'b1;
      end
    end

  assign div_o   = {hi_q, lo_q, 2'b01};
  assign test_o  = test_q;
  assign port_o  = port_q;
  assign valid_o = got_hi_q & got_lo_q;
endmodule

// File: rtl/synth_ctl_rx.sv
module synth_ctl_rx
  import synth_ctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_BYTE   = 8'hC8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       DIV_W       = 12,
  parameter int unsigned       TEST_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TEST_W-1:0] test_o,
  output logic              port_o,
  output logic              valid_o
);
  logic sda_s, scl_rise, scl_fall, start_p, stop_p, wr;
  logic [BYTE_W-1:0] rx_byte;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  byte_rx_engine #(.ADDR_BYTE(ADDR_BYTE)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_p), .stop_i(stop_p),
    .ack_o(sda_oe_o), .wr_o(wr), .byte_o(rx_byte)
  );

  synth_reg_bank #(.DIV_W(DIV_W), .TEST_W(TEST_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .byte_i(rx_byte),
    .div_o, .test_o, .port_o, .valid_o
  );
endmodule

// File: rtl/synth_ctl_rx_chk.sv
module synth_ctl_rx_chk #(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned TEST_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [DIV_W-1:0]  div_o,
  input logic [TEST_W-1:0] test_o,
  input logic              port_o,
  input logic              valid_o
);
  AST_ACK_ON_LOW_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i); // R7
  AST_ACK_OFF_LOW_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_i); // R7
  AST_VALID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R5
  AST_UPDATE_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(div_o) && $stable(test_o) && $stable(port_o)) |-> sda_oe_o); // R8
  AST_HI_GROUP_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o[DIV_W-1:5]) |-> ($stable(div_o[4:2]) && $stable(test_o) && $stable(port_o))); // R6
endmodule

bind synth_ctl_rx synth_ctl_rx_chk #(.DIV_W(DIV_W), .TEST_W(TEST_W)) u_chk (.*);

// File: tb/synth_ctl_rx_bench.sv
module synth_ctl_rx_bench;
  localparam int Q = 10;

  logic clk = 1'b0, rst_ni = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, port, valid;
  logic [11:0] div;
  logic [2:0] test;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  synth_ctl_rx u_synth_ctl_rx (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .div_o(div), .test_o(test), .port_o(port), .valid_o(valid)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [6:0] m_hi = '0;
  logic [2:0] m_lo = '0, m_t = '0;
  logic m_p = 0, m_g1 = 0, m_g2 = 0;

  // {addr, first data, second data, data count}
  localparam logic [25:0] VEC [0:7] = '{
    {8'hC8, 8'h1D, 8'h87, 2'd2},
    {8'hC8, 8'hF5, 8'h00, 2'd1},
    {8'hC8, 8'h2A, 8'h00, 2'd1},
    {8'hCA, 8'h11, 8'h88, 2'd2},
    {8'hC8, 8'h9C, 8'h40, 2'd2},
    {8'hC9, 8'h00, 8'hFF, 2'd2},
    {8'hC8, 8'h7F, 8'hFF, 2'd2},
    {8'h48, 8'h05, 8'h80, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] d);
    if (!d[7]) begin m_hi = d[6:0]; m_g1 = 1; end
    else begin m_lo = d[2:0]; m_p = d[3]; m_t = {d[4], d[5], d[6]}; m_g2 = 1; end
  endtask

  task automatic chk_regs(input string req);
    chk({req, " div"}, 32'(div), 32'({m_hi, m_lo, 2'b01}));
    chk({req, " test"}, 32'(test), 32'(m_t));
    chk({req, " port"}, 32'(port), 32'(m_p));
    chk({req, " valid"}, 32'(valid), 32'(m_g1 & m_g2));
  endtask

  task automatic bus_start;
    sda_m = 1; wq(1); scl_m = 1; wq(1); sda_m = 0; wq(1); scl_m = 0; wq(1);
  endtask

  task automatic bus_stop;
    sda_m = 0; wq(1); scl_m = 1; wq(1); sda_m = 1; wq(1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    send_bits(b, 8);
    sda_m = 1; wq(1); scl_m = 1; wq(1);
    chk({req, " ack"}, 32'(sda_oe), 32'(exp_ack));
    wq(1); scl_m = 0; wq(1);
    chk({req, " ack released R7"}, 32'(sda_oe), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ok;
    repeat (4) @(negedge clk);
    chk_regs("R4 reset");
    chk("R4 reset div", 32'(div), 32'h001);
    rst_ni = 1; wq(2);

    // group 2 alone must not raise valid
    bus_start; send_byte(8'hC8, 1, "R1 addr"); send_byte(8'hB2, 1, "R3 data");
    bus_stop; model_byte(8'hB2);
    chk_regs("R3 group2 alone");
    chk("R5 valid low", 32'(valid), 32'd0);

    for (int v = 0; v < 8; v++) begin
      ok = (VEC[v][25:18] == 8'hC8);
      bus_start;
      send_byte(VEC[v][25:18], ok, "R1 addr");
      send_byte(VEC[v][17:10], ok, "R9 data a");
      if (ok) model_byte(VEC[v][17:10]);
      if (VEC[v][1:0] == 2'd2) begin
        send_byte(VEC[v][9:2], ok, "R9 data b");
        if (ok) model_byte(VEC[v][9:2]);
      end
      bus_stop;
      chk_regs(ok ? "R2 R6 vec" : "R1 ignored vec");
    end
    chk("R5 valid set", 32'(valid), 32'd1);

    // STOP in mid byte
    bus_start; send_byte(8'hC8, 1, "R1 addr"); send_bits(8'h00, 5);
    bus_stop; chk_regs("R8 stop mid byte");

    // repeated START in mid byte, then new transfer
    bus_start; send_byte(8'hC8, 1, "R1 addr"); send_bits(8'h85, 3);
    bus_start; send_byte(8'hC8, 1, "R8 addr after restart");
    send_byte(8'h33, 1, "R8 data"); model_byte(8'h33);
    bus_stop; chk_regs("R8 restart");
    chk("R4 div lsbs", 32'(div[1:0]), 32'd1);

    // reset clears everything
    rst_ni = 0; wq(1);
    m_hi = 0; m_lo = 0; m_t = 0; m_p = 0; m_g1 = 0; m_g2 = 0;
    chk_regs("R5 reset again");
    rst_ni = 1; wq(2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule